// File: doc/BRIEF.md
# Vectored External Interrupt Entry Unit

This block sits beside the fetch sequencer of a 32-bit processor. It owns the program counter, the interrupt enable flag, a saved-return-address register and a 16-bit interrupt cause register. At every instruction boundary the sequencer raises `fetch_i`. If a request is pending and interrupts are enabled at that moment, the unit takes the interrupt in one step. It saves the current PC and the cause word from the device, disables further interrupts, jumps to a vector built from the device's 8-bit code, and pulses the acknowledge line for one cycle. Otherwise the fetch simply advances the PC by one instruction word.

The unit also executes the five interrupt-management instructions that the decoder hands it through `op_valid_i`/`op_i`. These are: return from interrupt, enable, disable, save interrupt state into two general registers, and restore that state from two general registers. It also handles machine run control. A hard start only works while stopped; it starts the machine at PC zero. A soft reset only works while running; it returns fetch to PC zero. Both leave interrupts disabled.

Top module: `irq_entry_unit`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `run_o`, `ie_o` and `iack_o` are 0 and `pc_o` is 0.
- R2: `start_i` while stopped sets `run_o` to 1, `pc_o` to 0 and `ie_o` to 0 at the next edge. While running, `start_i` has no effect.
- R3: `soft_rst_i` while running sets `pc_o` to 0 and `ie_o` to 0 at the next edge and keeps `run_o` at 1. While stopped it has no effect.
- R4: `fetch_i` while running, without an interrupt being taken, adds 4 to `pc_o`.
- R5: `fetch_i` with `ireq_i`=1 and `ie_o`=1 takes the interrupt. At the next edge, `pc_o` equals the vector, in which bits 11..4 hold `src_code_i` and all other bits are zero, and `ie_o` becomes 0.
- R6: On taking an interrupt, the saved PC register receives the PC value from before the fetch. The cause register receives `src_info_i`.
- R7: `iack_o` is 1 for exactly the one cycle after the edge that takes an interrupt, and 0 otherwise.
- R8: With `ie_o`=0, `ireq_i` is ignored: a fetch adds 4 and `iack_o` stays 0. Without `fetch_i`, `ireq_i` is never sampled.
- R9: Opcode 29 (return) loads `pc_o` from the saved PC and sets `ie_o` to 1 at the same edge.
- R10: Opcode 10 sets `ie_o` and opcode 11 clears it.
- R11: Opcode 16 (save) raises `ra_we_o` and `rb_we_o` in the same cycle. It drives the cause register on `ra_wdata_o` (the low 16 bits of R[ra]) and the saved PC on `rb_wdata_o`.
- R12: Opcode 17 (restore) loads the cause register from `ra_low_i` and the saved PC from `rb_val_i`.
- R13: `halt_i` while running clears `run_o`. While stopped, fetches and instructions change neither `pc_o` nor `ie_o`.
- R14: When `fetch_i` and `op_valid_i` are both high in one cycle, the fetch is performed and the instruction is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Hard start, honoured only while stopped |
| halt_i | input | 1 | Stop the machine |
| soft_rst_i | input | 1 | Soft reset, honoured only while running |
| fetch_i | input | 1 | Instruction boundary, start of fetch |
| ireq_i | input | 1 | External interrupt request |
| src_code_i | input | 8 | Device type code for the vector |
| src_info_i | input | 16 | Device cause word |
| op_valid_i | input | 1 | Interrupt-management instruction present |
| op_i | input | 5 | Opcode of that instruction |
| ra_low_i | input | 16 | Low half of R[ra] for restore |
| rb_val_i | input | 32 | R[rb] for restore |
| run_o | output | 1 | Machine running |
| pc_o | output | 32 | Program counter |
| ie_o | output | 1 | Interrupt enable flag |
| iack_o | output | 1 | Interrupt acknowledge pulse |
| ra_we_o | output | 1 | Write strobe for low half of R[ra] |
| ra_wdata_o | output | 16 | Cause word to write |
| rb_we_o | output | 1 | Write strobe for R[rb] |
| rb_wdata_o | output | 32 | Saved PC to write |

## Verification
A wrong enable flag shows at the very next fetch. Either a request is taken that should be ignored, so `pc_o` jumps to a vector and `iack_o` rises, or a request is missed and `pc_o` only steps by 4. A corrupted saved PC or cause register stays hidden until a save instruction puts it on the write ports, or a return jumps to the wrong address. For that reason the bench takes an interrupt for every one of the 256 device codes and reads both registers back after each one. Run-control faults appear one edge after the stimulus as a wrong `pc_o` or `run_o`.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int unsigned OPC_W = 5;

  typedef enum logic [OPC_W-1:0] {
    OPC_IRQ_EN   = 5'd10,
    OPC_IRQ_DIS  = 5'd11,
    OPC_SAVE_IRQ = 5'd16,
    OPC_LOAD_IRQ = 5'd17,
    OPC_IRQ_RET  = 5'd29
  } irq_opc_e;
endpackage

// File: rtl/irq_action_decode.sv
module irq_action_decode
  import irq_entry_pkg::*;
(
  input  logic             run_i,
  input  logic             ie_i,
  input  logic             start_i,
  input  logic             halt_i,
  input  logic             soft_rst_i,
  input  logic             fetch_i,
  input  logic             ireq_i,
  input  logic             op_valid_i,
  input  logic [OPC_W-1:0] op_i,
  output logic             do_start_o,
  output logic             do_soft_o,
  output logic             do_halt_o,
  output logic             do_take_o,
  output logic             do_step_o,
  output logic             do_ret_o,
  output logic             do_en_o,
  output logic             do_dis_o,
  output logic             do_save_o,
  output logic             do_load_o
);
  logic active;
  logic op_go;

  always_comb begin
    do_start_o = !run_i && start_i;
    do_soft_o  = run_i && soft_rst_i;
    do_halt_o  = run_i && !soft_rst_i && halt_i;
    active     = run_i && !soft_rst_i && !halt_i;
    do_take_o  = active && fetch_i && ireq_i && ie_i;
    do_step_o  = active && fetch_i && !do_take_o;
    op_go      = active && !fetch_i && op_valid_i;
    do_ret_o   = op_go && (op_i == OPC_IRQ_RET);
    do_en_o    = op_go && (op_i == OPC_IRQ_EN);
    do_dis_o   = op_go && (op_i == OPC_IRQ_DIS);
    do_save_o  = op_go && (op_i == OPC_SAVE_IRQ);
    do_load_o  = op_go && (op_i == OPC_LOAD_IRQ);
  end
endmodule

// File: rtl/irq_ctrl_state.sv
module irq_ctrl_state (
  input  logic clk,
  input  logic rst_n,
  input  logic do_start_i,
  input  logic do_soft_i,
  input  logic do_halt_i,
  input  logic do_take_i,
  input  logic do_ret_i,
  input  logic do_en_i,
  input  logic do_dis_i,
  output logic run_o,
  output logic ie_o,
  output logic iack_o
);
  logic run_q, run_d;
  logic ie_q, ie_d;
  logic iack_q, iack_d;

  always_comb begin
    run_d = run_q;
    if (do_start_i)     run_d = 1'b1;
    else if (do_halt_i) run_d = 1'b0;

    ie_d = ie_q;
    if (do_start_i || do_soft_i || do_take_i || do_dis_i) ie_d = 1'b0;
    else if (do_ret_i || do_en_i)                          ie_d = 1'b1;

    iack_d = do_take_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      iack_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      ie_q   <= ie_d;
      iack_q <= iack_d;
    end
  end

  assign run_o  = run_q;
  assign ie_o   = ie_q;
  assign iack_o = iack_q;
endmodule

// File: rtl/irq_save_regs.sv
module irq_save_regs #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned INFO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_take_i,
  input  logic              do_load_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [INFO_W-1:0] src_info_i,
  input  logic [INFO_W-1:0] ra_low_i,
  input  logic [XLEN-1:0]   rb_val_i,
  output logic [XLEN-1:0]   ret_pc_o,
  output logic [INFO_W-1:0] cause_o
);
  logic [XLEN-1:0]   ret_q, ret_d;
  logic [INFO_W-1:0] cause_q, cause_d;
  logic              ld_en;

  always_comb begin
    ld_en   = do_take_i || do_load_i;
    ret_d   = do_take_i ? pc_i       : rb_val_i;
    cause_d = do_take_i ? src_info_i : ra_low_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_q   <= '0;
      cause_q <= '0;
    end else if (ld_en) begin
      ret_q   <= ret_d;
      cause_q <= cause_d;
    end
  end

  assign ret_pc_o = ret_q;
  assign cause_o  = cause_q;
endmodule

// File: rtl/irq_pc_reg.sv
module irq_pc_reg #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned VEC_LSB  = 4,
  parameter int unsigned INSN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_start_i,
  input  logic              do_soft_i,
  input  logic              do_take_i,
  input  logic              do_step_i,
  input  logic              do_ret_i,
  input  logic [CODE_W-1:0] src_code_i,
  input  logic [XLEN-1:0]   ret_pc_i,
  output logic [XLEN-1:0]   pc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_LEN);

  logic [XLEN-1:0] pc_q, pc_d, vec;
  logic            pc_en;

  generate
    if (VEC_LSB + CODE_W < XLEN) begin : g_hi_pad
      assign vec[XLEN-1:VEC_LSB+CODE_W] = '0;
    end
    if (VEC_LSB > 0) begin : g_lo_pad
      assign vec[VEC_LSB-1:0] = '0;
    end
  endgenerate
  assign vec[VEC_LSB +: CODE_W] = src_code_i;

  always_comb begin
    pc_en = do_start_i || do_soft_i || do_take_i || do_ret_i || do_step_i;
    if (do_start_i || do_soft_i) pc_d = '0;
    else if (do_take_i)          pc_d = vec;
    else if (do_ret_i)           pc_d = ret_pc_i;
    else                         pc_d = pc_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_entry_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned INFO_W  = 16,
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned VEC_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              halt_i,
  input  logic              soft_rst_i,
  input  logic              fetch_i,
  input  logic              ireq_i,
  input  logic [CODE_W-1:0] src_code_i,
  input  logic [INFO_W-1:0] src_info_i,
  input  logic              op_valid_i,
  input  logic [OPC_W-1:0]  op_i,
  input  logic [INFO_W-1:0] ra_low_i,
  input  logic [XLEN-1:0]   rb_val_i,
  output logic              run_o,
  output logic [XLEN-1:0]   pc_o,
  output logic              ie_o,
  output logic              iack_o,
  output logic              ra_we_o,
  output logic [INFO_W-1:0] ra_wdata_o,
  output logic              rb_we_o,
  output logic [XLEN-1:0]   rb_wdata_o
);
  logic do_start, do_soft, do_halt, do_take, do_step;
  logic do_ret, do_en, do_dis, do_save, do_load;
  logic run, ie;
  logic [XLEN-1:0]   pc, ret_pc;
  logic [INFO_W-1:0] cause;

  irq_action_decode u_dec (
    .run_i(run), .ie_i(ie), .start_i(start_i), .halt_i(halt_i),
    .soft_rst_i(soft_rst_i), .fetch_i(fetch_i), .ireq_i(ireq_i),
    .op_valid_i(op_valid_i), .op_i(op_i),
    .do_start_o(do_start), .do_soft_o(do_soft), .do_halt_o(do_halt),
    .do_take_o(do_take), .do_step_o(do_step), .do_ret_o(do_ret),
    .do_en_o(do_en), .do_dis_o(do_dis), .do_save_o(do_save),
    .do_load_o(do_load)
  );

  irq_ctrl_state u_state (
    .clk(clk), .rst_n(rst_n), .do_start_i(do_start), .do_soft_i(do_soft),
    .do_halt_i(do_halt), .do_take_i(do_take), .do_ret_i(do_ret),
    .do_en_i(do_en), .do_dis_i(do_dis),
    .run_o(run), .ie_o(ie), .iack_o(iack_o)
  );

  irq_save_regs #(.XLEN(XLEN), .INFO_W(INFO_W)) u_save (
    .clk(clk), .rst_n(rst_n), .do_take_i(do_take), .do_load_i(do_load),
    .pc_i(pc), .src_info_i(src_info_i), .ra_low_i(ra_low_i),
    .rb_val_i(rb_val_i), .ret_pc_o(ret_pc), .cause_o(cause)
  );

  irq_pc_reg #(.XLEN(XLEN), .CODE_W(CODE_W), .VEC_LSB(VEC_LSB), .INSN_LEN(4)) u_pc (
    .clk(clk), .rst_n(rst_n), .do_start_i(do_start), .do_soft_i(do_soft),
    .do_take_i(do_take), .do_step_i(do_step), .do_ret_i(do_ret),
    .src_code_i(src_code_i), .ret_pc_i(ret_pc), .pc_o(pc)
  );

  assign run_o      = run;
  assign ie_o       = ie;
  assign pc_o       = pc;
  assign ra_we_o    = do_save;
  assign rb_we_o    = do_save;
  assign ra_wdata_o = cause;
  assign rb_wdata_o = ret_pc;
endmodule

// File: rtl/irq_entry_checker.sv
module irq_entry_checker #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned INFO_W  = 16,
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned VEC_LSB = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              halt_i,
  input logic              soft_rst_i,
  input logic              fetch_i,
  input logic              ireq_i,
  input logic [CODE_W-1:0] src_code_i,
  input logic              op_valid_i,
  input logic [4:0]        op_i,
  input logic              run_o,
  input logic [XLEN-1:0]   pc_o,
  input logic              ie_o,
  input logic              iack_o,
  input logic              ra_we_o,
  input logic              rb_we_o
);
  logic [XLEN-1:0] exp_vec;
  logic            live;

  always_comb begin
    exp_vec = '0;
    exp_vec[VEC_LSB +: CODE_W] = src_code_i;
    live = run_o && !soft_rst_i && !halt_i;
  end

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |=> !iack_o); // R7

  AST_TAKE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (live && fetch_i && ireq_i && ie_o) |=> (pc_o == $past(exp_vec)) && !ie_o && iack_o); // R5

  AST_MASKED_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (live && fetch_i && !ie_o) |=> !iack_o && (pc_o == $past(pc_o) + 32'd4)); // R8

  AST_RET_SETS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !fetch_i && op_valid_i && op_i == 5'd29) |=> ie_o); // R9

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && soft_rst_i) |=> (pc_o == '0) && !ie_o && run_o); // R3

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !start_i) |=> $stable(pc_o) && $stable(ie_o) && !run_o); // R13

  AST_SAVE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ra_we_o |-> rb_we_o && run_o); // R11
endmodule

bind irq_entry_unit irq_entry_checker #(
  .XLEN(XLEN), .INFO_W(INFO_W), .CODE_W(CODE_W), .VEC_LSB(VEC_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .halt_i(halt_i),
  .soft_rst_i(soft_rst_i), .fetch_i(fetch_i), .ireq_i(ireq_i),
  .src_code_i(src_code_i), .op_valid_i(op_valid_i), .op_i(op_i),
  .run_o(run_o), .pc_o(pc_o), .ie_o(ie_o), .iack_o(iack_o),
  .ra_we_o(ra_we_o), .rb_we_o(rb_we_o)
);

// File: tb/irq_entry_unit_test.sv
`timescale 1ns/1ps
module irq_entry_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, halt_i, soft_rst_i, fetch_i, ireq_i, op_valid_i;
  logic [7:0]  src_code_i;
  logic [15:0] src_info_i, ra_low_i;
  logic [4:0]  op_i;
  logic [31:0] rb_val_i;
  logic        run_o, ie_o, iack_o, ra_we_o, rb_we_o;
  logic [31:0] pc_o, rb_wdata_o;
  logic [15:0] ra_wdata_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_pc, saved;
  logic [15:0] info;

  always #4 clk = ~clk;

  irq_entry_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .halt_i(halt_i),
    .soft_rst_i(soft_rst_i), .fetch_i(fetch_i), .ireq_i(ireq_i),
    .src_code_i(src_code_i), .src_info_i(src_info_i), .op_valid_i(op_valid_i),
    .op_i(op_i), .ra_low_i(ra_low_i), .rb_val_i(rb_val_i), .run_o(run_o),
    .pc_o(pc_o), .ie_o(ie_o), .iack_o(iack_o), .ra_we_o(ra_we_o),
    .ra_wdata_o(ra_wdata_o), .rb_we_o(rb_we_o), .rb_wdata_o(rb_wdata_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    start_i = 0; halt_i = 0; soft_rst_i = 0; fetch_i = 0; ireq_i = 0;
    op_valid_i = 0; op_i = '0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic run_op(input logic [4:0] op);
    op_valid_i = 1; op_i = op; tick(); idle();
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    src_code_i = '0; src_info_i = '0; ra_low_i = '0; rb_val_i = '0;
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 run", run_o, 0); chk("R1 pc", pc_o, 0);
    chk("R1 ie", ie_o, 0);   chk("R1 iack", iack_o, 0);

    fetch_i = 1; tick(); idle();
    chk("R13 stopped fetch", pc_o, 0);
    run_op(5'd10);
    chk("R13 stopped een", ie_o, 0);
    soft_rst_i = 1; tick(); idle();
    chk("R3 soft while stopped run", run_o, 0);

    start_i = 1; tick(); idle();
    chk("R2 run", run_o, 1); chk("R2 pc", pc_o, 0); chk("R2 ie", ie_o, 0);

    exp_pc = 0;
    for (int i = 0; i < 3; i++) begin
      fetch_i = 1; tick(); idle();
      exp_pc += 4;
      chk("R4 step", pc_o, exp_pc);
    end

    fetch_i = 1; ireq_i = 1; src_code_i = 8'h5A; tick(); idle();
    exp_pc += 4;
    chk("R8 masked pc", pc_o, exp_pc); chk("R8 masked iack", iack_o, 0);

    start_i = 1; tick(); idle();
    chk("R2 start while running", pc_o, exp_pc);

    run_op(5'd10);
    chk("R10 een", ie_o, 1);
    ireq_i = 1; tick(); idle();
    chk("R8 no fetch pc", pc_o, exp_pc); chk("R8 no fetch iack", iack_o, 0);
    run_op(5'd11);
    chk("R10 edi", ie_o, 0);
    run_op(5'd10);

    for (int c = 0; c < 256; c++) begin
      fetch_i = 1; tick(); idle();
      exp_pc += 4;
      chk("R4 step", pc_o, exp_pc);
      info = {8'(c), ~8'(c)};
      saved = exp_pc;
      fetch_i = 1; ireq_i = 1; src_code_i = 8'(c); src_info_i = info;
      tick(); idle();
      src_code_i = ~8'(c); src_info_i = 16'h0;
      chk("R5 vector", pc_o, 32'(c) << 4);
      chk("R5 ie cleared", ie_o, 0);
      chk("R7 ack high", iack_o, 1);
      tick();
      chk("R7 ack low", iack_o, 0);
      op_valid_i = 1; op_i = 5'd16; #1;
      chk("R11 ra we", ra_we_o, 1); chk("R11 rb we", rb_we_o, 1);
      chk("R6 cause", ra_wdata_o, info); chk("R6 saved pc", rb_wdata_o, saved);
      tick(); idle();
      run_op(5'd29);
      chk("R9 return pc", pc_o, saved); chk("R9 return ie", ie_o, 1);
    end

    ra_low_i = 16'h1234; rb_val_i = 32'hDEAD_BEE0;
    run_op(5'd17);
    op_valid_i = 1; op_i = 5'd16; #1;
    chk("R12 restore cause", ra_wdata_o, 16'h1234);
    chk("R12 restore pc", rb_wdata_o, 32'hDEAD_BEE0);
    tick(); idle();
    run_op(5'd29);
    exp_pc = 32'hDEAD_BEE0;
    chk("R9 return after restore", pc_o, exp_pc);

    fetch_i = 1; op_valid_i = 1; op_i = 5'd11; tick(); idle();
    exp_pc += 4;
    chk("R14 fetch wins pc", pc_o, exp_pc); chk("R14 op dropped", ie_o, 1);

    soft_rst_i = 1; tick(); idle();
    chk("R3 soft pc", pc_o, 0); chk("R3 soft ie", ie_o, 0); chk("R3 soft run", run_o, 1);

    fetch_i = 1; tick(); idle();
    halt_i = 1; tick(); idle();
    chk("R13 halted", run_o, 0);
    soft_rst_i = 1; tick(); idle();
    chk("R3 soft ignored when stopped", pc_o, 4);
    run_op(5'd29);
    chk("R13 stopped return", pc_o, 4);
    start_i = 1; tick(); idle();
    chk("R2 restart pc", pc_o, 0); chk("R2 restart run", run_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule